// File: doc/BRIEF.md
# Macroblock Input Request Sequencer

This block runs the pixel input side of a block-based video encoder. A rising edge on the frame-start input arms it; after a fixed lead time it opens one request window per macroblock slot, each slot lasting a fixed number of system-clock cycles. While the request line is high the upstream preprocessor delivers one macroblock, one pixel per rising edge of a pixel strobe. Each captured pixel is written onward with an address made of a sub-block index and its row and column inside that 8×8 (parameterised) sub-block.

The sequencer also numbers the macroblocks the way the coded stream expects. Within each group of blocks it counts macroblocks from 1. In full-resolution mode groups are numbered 1, 2, 3 and onward, and after every row of macroblocks except the last one a dummy slot is inserted. The dummy slot is as long as a normal slot but never raises the request. In quarter-resolution mode no dummy slots occur and the groups carry the odd numbers 1, 3, 5. After the last macroblock of a frame the block stays idle until the next frame start. A sticky error flag reports a macroblock that came in short and any pixel strobe that arrives outside a request window.

Top module: `mbis_request_sequencer`

## Requirements
- R1: The first request of a frame rises exactly REQ_DELAY cycles after the clock edge that samples a low-to-high change on `frame_start_i`.
- R2: In every non-dummy slot the request stays high for exactly REQ_WIN consecutive cycles.
- R3: Successive request rises without a dummy slot between them are exactly MB_PERIOD cycles apart, and never closer.
- R4: Each captured pixel appears one cycle later on the write port with `wr_en_o` high. The k-th pixel of a macroblock (k from 0) carries sub-block k/(BLK·BLK), where 0 to 3 are luminance, 4 is U and 5 is V. Its row is (k mod BLK²)/BLK and its column is k mod BLK.
- R5: With `cif_mode_i` high at frame start, a dummy slot of MB_PERIOD cycles follows every ROW_MBS-th macroblock except the last of the frame, and the request stays low during it. With `cif_mode_i` low no dummy slot is inserted.
- R6: A pixel is captured only on a low-to-high change of `pix_stb_i`; a strobe held high for several cycles yields one pixel.
- R7: `mb_num_o` gives the current macroblock's position in its group, 1 to MBS_PER_GOB. It restarts at 1 on every frame start.
- R8: `gob_num_o` counts 1 to GOBS_CIF in full-resolution mode. In quarter-resolution mode it takes the odd values 1, 3, 5 and onward for GOBS_QCIF groups.
- R9: `err_o` is set when a request window closes with fewer than 6·BLK² pixels captured. It stays set until the next frame start clears it.
- R10: A strobe edge while the request is low sets `err_o` and produces no write.
- R11: After the last macroblock of a frame the request stays low until the next frame start.
- R12: After reset `req_o`, `wr_en_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame start; its rising edge starts a frame |
| cif_mode_i | input | 1 | 1 = full resolution, 0 = quarter resolution; sampled at frame start |
| pix_stb_i | input | 1 | Pixel strobe, synchronous to clk |
| pix_i | input | 8 | Pixel value |
| req_o | output | 1 | Macroblock request window |
| wr_en_o | output | 1 | Pixel write valid |
| wr_data_o | output | 8 | Pixel value being written |
| wr_sub_o | output | 3 | Sub-block index 0..5 |
| wr_row_o | output | $clog2(BLK) | Row inside the sub-block |
| wr_col_o | output | $clog2(BLK) | Column inside the sub-block |
| mb_num_o | output | $clog2(MBS_PER_GOB+1) | Macroblock number inside its group |
| gob_num_o | output | $clog2(max(GOBS_CIF,2·GOBS_QCIF−1)+1) | Group number |
| err_o | output | 1 | Sticky input error |

## Verification
A slot counter that is off by even one shows at once as a wrong distance between request rises. An early dummy insertion doubles the gap at the wrong macroblock and shifts every later macroblock and group number. The bench times every rise and fall against a free-running cycle count and compares the numbers at each rise, so a timing fault is reported at the next request edge. A wrong pixel counter shows up as a scrambled sub-block, row or column on the very next write, where the scoreboard catches it. A wrong error decision shows up at the window close of the short macroblock, or one cycle after a stray strobe.

// File: rtl/mbis_pkg.sv
package mbis_pkg;

    // Six sub-blocks per macroblock: four luma, then U, then V
    localparam int SUBS_PER_MB = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_SLOT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic dummy;   // current slot carries no data
        logic last;    // current slot holds the final macroblock of the frame
    } slot_flags_t;

    // Group label seen in the coded stream for a zero-based group index
    function automatic int unsigned gob_label(input int unsigned idx, input logic cif);
        return cif ? idx + 1 : 2 * idx + 1;
    endfunction

endpackage

// File: rtl/mbis_slot_timer.sv
module mbis_slot_timer
    import mbis_pkg::*;
#(
    parameter int REQ_DELAY = 184,
    parameter int REQ_WIN   = 1871,
    parameter int MB_PERIOD = 2064
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start_i,
    input  slot_flags_t flags_i,
    output logic        frame_go_o,
    output logic        slot_end_o,
    output logic        req_o,
    output logic        win_close_o
);

    localparam int CNT_MAX = (MB_PERIOD > REQ_DELAY) ? MB_PERIOD : REQ_DELAY;
    localparam int CW      = $clog2(CNT_MAX);
    localparam logic [CW-1:0] LEAD_LAST = CW'(REQ_DELAY - 1);
    localparam logic [CW-1:0] SLOT_LAST = CW'(MB_PERIOD - 1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(REQ_WIN - 1);
    localparam logic [CW-1:0] WIN_LEN   = CW'(REQ_WIN);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          fs_q;

    assign frame_go_o  = frame_start_i & ~fs_q;
    assign slot_end_o  = (state == ST_SLOT) && (cnt == SLOT_LAST) && !frame_go_o;
    assign req_o       = (state == ST_SLOT) && !flags_i.dummy && (cnt < WIN_LEN);
    assign win_close_o = (state == ST_SLOT) && !flags_i.dummy && (cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q  <= 1'b0;
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            fs_q <= frame_start_i;
            if (frame_go_o) begin
                state <= ST_LEAD;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_LEAD: begin
                        if (cnt == LEAD_LAST) begin
                            state <= ST_SLOT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_SLOT: begin
                        if (cnt == SLOT_LAST) begin
                            cnt <= '0;
                            if (flags_i.last && !flags_i.dummy)
                                state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mbis_mb_position.sv
module mbis_mb_position
    import mbis_pkg::*;
#(
    parameter int MBS_PER_GOB = 33,
    parameter int ROW_MBS     = 11,
    parameter int GOBS_CIF    = 12,
    parameter int GOBS_QCIF   = 3,
    parameter int MW          = 6,
    parameter int GW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_go_i,
    input  logic          slot_end_i,
    input  logic          cif_mode_i,
    output slot_flags_t   flags_o,
    output logic [MW-1:0] mb_num_o,
    output logic [GW-1:0] gob_num_o
);

    localparam int GMAX = (GOBS_CIF > GOBS_QCIF) ? GOBS_CIF : GOBS_QCIF;
    localparam int GIW  = $clog2(GMAX + 1);
    localparam int CLW  = $clog2(ROW_MBS + 1);
    localparam logic [MW-1:0]  MB_LAST  = MW'(MBS_PER_GOB - 1);
    localparam logic [CLW-1:0] COL_LAST = CLW'(ROW_MBS - 1);
    localparam logic [GIW-1:0] GOB_LAST_CIF  = GIW'(GOBS_CIF - 1);
    localparam logic [GIW-1:0] GOB_LAST_QCIF = GIW'(GOBS_QCIF - 1);

    logic [MW-1:0]  mb_idx;
    logic [GIW-1:0] gob_idx;
    logic [CLW-1:0] col_idx;
    logic           dummy_q;
    logic           cif_q;
    logic           row_end;
    logic           last_mb;

    assign row_end = (col_idx == COL_LAST);
    assign last_mb = (mb_idx == MB_LAST) &&
                     (gob_idx == (cif_q ? GOB_LAST_CIF : GOB_LAST_QCIF));

    assign flags_o.dummy = dummy_q;
    assign flags_o.last  = last_mb;
    assign mb_num_o      = mb_idx + 1'b1;
    assign gob_num_o     = GW'(gob_label(int'(gob_idx), cif_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            mb_idx  <= '0;
            gob_idx <= '0;
            col_idx <= '0;
            dummy_q <= 1'b0;
            cif_q   <= 1'b0;
        end else if (frame_go_i) begin
            mb_idx  <= '0;
            gob_idx <= '0;
            col_idx <= '0;
            dummy_q <= 1'b0;
            cif_q   <= cif_mode_i;
        end else if (slot_end_i) begin
            if (dummy_q) begin
                dummy_q <= 1'b0;
            end else if (!last_mb) begin
                dummy_q <= cif_q & row_end;
                col_idx <= row_end ? '0 : col_idx + 1'b1;
                if (mb_idx == MB_LAST) begin
                    mb_idx  <= '0;
                    gob_idx <= gob_idx + 1'b1;
                end else begin
                    mb_idx <= mb_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mbis_pixel_capture.sv
module mbis_pixel_capture #(
    parameter int BLK    = 8,
    parameter int PIX_MB = 384
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_go_i,
    input  logic                   slot_start_i,
    input  logic                   req_i,
    input  logic                   win_close_i,
    input  logic                   pix_stb_i,
    input  logic [7:0]             pix_i,
    output logic                   wr_en_o,
    output logic [7:0]             wr_data_o,
    output logic [2:0]             wr_sub_o,
    output logic [$clog2(BLK)-1:0] wr_row_o,
    output logic [$clog2(BLK)-1:0] wr_col_o,
    output logic                   err_o
);

    localparam int LB = $clog2(BLK);
    localparam int PW = $clog2(PIX_MB + 1);
    localparam logic [PW-1:0] FULL = PW'(PIX_MB);

    logic [PW-1:0] pix_cnt;
    logic [PW-1:0] cnt_after;
    logic          stb_q;
    logic          stb_rise;
    logic          take;
    logic          stray;
    logic          short_mb;

    assign stb_rise  = pix_stb_i & ~stb_q;
    assign take      = stb_rise & req_i & (pix_cnt < FULL);
    assign stray     = stb_rise & ~req_i;
    assign cnt_after = pix_cnt + PW'(take);
    assign short_mb  = win_close_i && (cnt_after != FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q     <= 1'b0;
            pix_cnt   <= '0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
            wr_sub_o  <= '0;
            wr_row_o  <= '0;
            wr_col_o  <= '0;
            err_o     <= 1'b0;
        end else begin
            stb_q   <= pix_stb_i;
            wr_en_o <= take;
            if (slot_start_i)
                pix_cnt <= '0;
            else if (take)
                pix_cnt <= pix_cnt + 1'b1;
            if (take) begin
                wr_data_o <= pix_i;
                wr_sub_o  <= pix_cnt[2*LB +: 3];
                wr_row_o  <= pix_cnt[LB +: LB];
                wr_col_o  <= pix_cnt[0 +: LB];
            end
            if (frame_go_i)
                err_o <= 1'b0;
            else if (stray || short_mb)
                err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/mbis_request_sequencer.sv
module mbis_request_sequencer
    import mbis_pkg::*;
#(
    parameter int BLK         = 8,
    parameter int MBS_PER_GOB = 33,
    parameter int ROW_MBS     = 11,
    parameter int GOBS_CIF    = 12,
    parameter int GOBS_QCIF   = 3,
    parameter int REQ_DELAY   = 184,
    parameter int REQ_WIN     = 1871,
    parameter int MB_PERIOD   = 2064,
    localparam int LB      = $clog2(BLK),
    localparam int MW      = $clog2(MBS_PER_GOB + 1),
    localparam int GOB_MAX = (GOBS_CIF > 2 * GOBS_QCIF - 1) ? GOBS_CIF : 2 * GOBS_QCIF - 1,
    localparam int GW      = $clog2(GOB_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start_i,
    input  logic          cif_mode_i,
    input  logic          pix_stb_i,
    input  logic [7:0]    pix_i,
    output logic          req_o,
    output logic          wr_en_o,
    output logic [7:0]    wr_data_o,
    output logic [2:0]    wr_sub_o,
    output logic [LB-1:0] wr_row_o,
    output logic [LB-1:0] wr_col_o,
    output logic [MW-1:0] mb_num_o,
    output logic [GW-1:0] gob_num_o,
    output logic          err_o
);

    localparam int PIX_MB = SUBS_PER_MB * BLK * BLK;

    slot_flags_t flags;
    logic        frame_go;
    logic        slot_end;
    logic        win_close;
    logic        slot_start;
    logic        slot_dummy;

    assign slot_start = frame_go | slot_end;
    assign slot_dummy = flags.dummy;

    mbis_slot_timer #(
        .REQ_DELAY (REQ_DELAY),
        .REQ_WIN   (REQ_WIN),
        .MB_PERIOD (MB_PERIOD)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start_i),
        .flags_i       (flags),
        .frame_go_o    (frame_go),
        .slot_end_o    (slot_end),
        .req_o         (req_o),
        .win_close_o   (win_close)
    );

    mbis_mb_position #(
        .MBS_PER_GOB (MBS_PER_GOB),
        .ROW_MBS     (ROW_MBS),
        .GOBS_CIF    (GOBS_CIF),
        .GOBS_QCIF   (GOBS_QCIF),
        .MW          (MW),
        .GW          (GW)
    ) u_pos (
        .clk        (clk),
        .rst        (rst),
        .frame_go_i (frame_go),
        .slot_end_i (slot_end),
        .cif_mode_i (cif_mode_i),
        .flags_o    (flags),
        .mb_num_o   (mb_num_o),
        .gob_num_o  (gob_num_o)
    );

    mbis_pixel_capture #(
        .BLK    (BLK),
        .PIX_MB (PIX_MB)
    ) u_cap (
        .clk          (clk),
        .rst          (rst),
        .frame_go_i   (frame_go),
        .slot_start_i (slot_start),
        .req_i        (req_o),
        .win_close_i  (win_close),
        .pix_stb_i    (pix_stb_i),
        .pix_i        (pix_i),
        .wr_en_o      (wr_en_o),
        .wr_data_o    (wr_data_o),
        .wr_sub_o     (wr_sub_o),
        .wr_row_o     (wr_row_o),
        .wr_col_o     (wr_col_o),
        .err_o        (err_o)
    );

endmodule

// File: rtl/mbis_checker.sv
module mbis_checker #(
    parameter int REQ_WIN     = 1871,
    parameter int MB_PERIOD   = 2064,
    parameter int MBS_PER_GOB = 33,
    parameter int MW          = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          req_o,
    input logic          wr_en_o,
    input logic [2:0]    wr_sub_o,
    input logic [MW-1:0] mb_num_o,
    input logic          err_o,
    input logic          frame_go,
    input logic          slot_dummy
);

    localparam int HW = $clog2(MB_PERIOD + 1);

    logic [HW-1:0] hi_cnt;
    logic [HW-1:0] gap_cnt;
    logic          seen_rise;

    always_ff @(posedge clk) begin
        if (rst || frame_go) begin
            hi_cnt    <= '0;
            gap_cnt   <= '0;
            seen_rise <= 1'b0;
        end else begin
            hi_cnt <= req_o ? hi_cnt + 1'b1 : '0;
            if (req_o && hi_cnt == '0) begin
                gap_cnt   <= HW'(1);
                seen_rise <= 1'b1;
            end else if (gap_cnt < HW'(MB_PERIOD)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R2: a window that closes on its own has lasted exactly REQ_WIN cycles
    a_r2_window_length: assert property (@(posedge clk) disable iff (rst)
        (!req_o && hi_cnt != '0) |-> (hi_cnt == HW'(REQ_WIN)));

    // R2: a window never runs past REQ_WIN cycles
    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (hi_cnt < HW'(REQ_WIN)));

    // R3: request rises are at least one slot apart
    a_r3_rise_spacing: assert property (@(posedge clk) disable iff (rst)
        (req_o && hi_cnt == '0 && seen_rise) |-> (gap_cnt >= HW'(MB_PERIOD)));

    // R5: no request during a dummy slot
    a_r5_dummy_quiet: assert property (@(posedge clk) disable iff (rst)
        slot_dummy |-> !req_o);

    // R10: every write comes from a strobe sampled inside a window
    a_r10_write_in_window: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(req_o));

    // R4: written sub-block index stays within the six of a macroblock
    a_r4_sub_range: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_sub_o < 3'd6));

    // R7: macroblock number stays in range
    a_r7_mb_range: assert property (@(posedge clk) disable iff (rst)
        (mb_num_o >= MW'(1)) && (mb_num_o <= MW'(MBS_PER_GOB)));

    // R9: a frame start always clears the error flag
    a_r9_err_cleared: assert property (@(posedge clk) disable iff (rst)
        frame_go |=> !err_o);

endmodule

bind mbis_request_sequencer mbis_checker #(
    .REQ_WIN     (REQ_WIN),
    .MB_PERIOD   (MB_PERIOD),
    .MBS_PER_GOB (MBS_PER_GOB),
    .MW          (MW)
) i_mbis_checker (
    .clk        (clk),
    .rst        (rst),
    .req_o      (req_o),
    .wr_en_o    (wr_en_o),
    .wr_sub_o   (wr_sub_o),
    .mb_num_o   (mb_num_o),
    .err_o      (err_o),
    .frame_go   (frame_go),
    .slot_dummy (slot_dummy)
);

// File: tb/test_mbis_request_sequencer.sv
module test_mbis_request_sequencer;

    localparam int BLK       = 2;
    localparam int MBS       = 6;
    localparam int ROWM      = 3;
    localparam int GCIF      = 4;
    localparam int GQCIF     = 2;
    localparam int DELAY     = 6;
    localparam int WIN       = 60;
    localparam int PERIOD    = 70;
    localparam int LB        = $clog2(BLK);
    localparam int MW        = $clog2(MBS + 1);
    localparam int GOB_MAX   = (GCIF > 2 * GQCIF - 1) ? GCIF : 2 * GQCIF - 1;
    localparam int GW        = $clog2(GOB_MAX + 1);
    localparam int PIX       = 6 * BLK * BLK;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic          cif_mode = 1'b0;
    logic          pix_stb = 1'b0;
    logic [7:0]    pix = '0;
    logic          req;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [2:0]    wr_sub;
    logic [LB-1:0] wr_row;
    logic [LB-1:0] wr_col;
    logic [MW-1:0] mb_num;
    logic [GW-1:0] gob_num;
    logic          err;

    mbis_request_sequencer #(
        .BLK (BLK), .MBS_PER_GOB (MBS), .ROW_MBS (ROWM),
        .GOBS_CIF (GCIF), .GOBS_QCIF (GQCIF),
        .REQ_DELAY (DELAY), .REQ_WIN (WIN), .MB_PERIOD (PERIOD)
    ) i_mbis_request_sequencer (
        .clk (clk), .rst (rst), .frame_start_i (frame_start),
        .cif_mode_i (cif_mode), .pix_stb_i (pix_stb), .pix_i (pix),
        .req_o (req), .wr_en_o (wr_en), .wr_data_o (wr_data),
        .wr_sub_o (wr_sub), .wr_row_o (wr_row), .wr_col_o (wr_col),
        .mb_num_o (mb_num), .gob_num_o (gob_num), .err_o (err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]    sub;
        logic [LB-1:0] row;
        logic [LB-1:0] col;
        logic [7:0]    data;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string req_tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on every write
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", "write with nothing expected", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(wr_data == e.data, "R4", "pixel data", int'(wr_data), int'(e.data));
                check({wr_sub, wr_row, wr_col} == {e.sub, e.row, e.col}, "R4",
                      "pixel address", int'({wr_sub, wr_row, wr_col}),
                      int'({e.sub, e.row, e.col}));
            end
        end
    end

    // Driver: sends npix pixels of macroblock tag, pushing each expected write
    task automatic send_mb(input int tag, input int npix, input bit long_first);
        for (int k = 0; k < npix; k++) begin
            exp_t e;
            e.data = 8'((k * 7 + tag * 13 + 5) & 255);
            e.sub  = 3'(k / (BLK * BLK));
            e.row  = LB'((k % (BLK * BLK)) / BLK);
            e.col  = LB'(k % BLK);
            sb_q.push_back(e);
            pix     = e.data;
            pix_stb = 1'b1;
            repeat ((long_first && k == 0) ? 3 : 1) @(negedge clk);
            pix_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_frame(input bit cif, output int c0);
        @(negedge clk);
        cif_mode    = cif;
        frame_start = 1'b1;
        c0          = cyc;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_level(input bit lvl, output int t);
        while (req !== lvl) @(negedge clk);
        t = cyc;
    endtask

    task automatic idle_check();
        bit seen = 1'b0;
        repeat (3 * PERIOD) begin
            @(negedge clk);
            if (req) seen = 1'b1;
        end
        check(!seen, "R11", "request after last macroblock", int'(seen), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WDOG", "watchdog expired", cyc, 0);
            summary();
        end
    end

    initial begin
        int c0, t_rise, t_fall, t_prev, nmb;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req == 1'b0, "R12", "req after reset", int'(req), 0);
        check(wr_en == 1'b0, "R12", "wr_en after reset", int'(wr_en), 0);
        check(err == 1'b0, "R12", "err after reset", int'(err), 0);

        // Full-resolution frame
        pulse_frame(1'b1, c0);
        t_prev = 0;
        nmb = GCIF * MBS;
        for (int i = 0; i < nmb; i++) begin
            wait_level(1'b1, t_rise);
            if (i == 0)
                check(t_rise - c0 == 1 + DELAY, "R1", "lead time", t_rise - c0, 1 + DELAY);
            else if (i % ROWM == 0)
                check(t_rise - t_prev == 2 * PERIOD, "R5", "gap across dummy slot",
                      t_rise - t_prev, 2 * PERIOD);
            else
                check(t_rise - t_prev == PERIOD, "R3", "slot spacing", t_rise - t_prev, PERIOD);
            check(int'(mb_num) == i % MBS + 1, "R7", "macroblock number", int'(mb_num), i % MBS + 1);
            check(int'(gob_num) == i / MBS + 1, "R8", "full-res group number",
                  int'(gob_num), i / MBS + 1);
            send_mb(i, PIX, i == 1);  // R6: first strobe of MB 1 held high 3 cycles
            wait_level(1'b0, t_fall);
            check(t_fall - t_rise == WIN, "R2", "window length", t_fall - t_rise, WIN);
            t_prev = t_rise;
        end
        check(err == 1'b0, "R9", "err after complete frame", int'(err), 0);
        idle_check();
        check(sb_q.size() == 0, "R6", "pending expected pixels", sb_q.size(), 0);

        // Quarter-resolution frame with one short macroblock
        pulse_frame(1'b0, c0);
        nmb = GQCIF * MBS;
        for (int i = 0; i < nmb; i++) begin
            wait_level(1'b1, t_rise);
            if (i == 0)
                check(t_rise - c0 == 1 + DELAY, "R1", "lead time", t_rise - c0, 1 + DELAY);
            else
                check(t_rise - t_prev == PERIOD, "R5", "no dummy in quarter-res",
                      t_rise - t_prev, PERIOD);
            check(int'(mb_num) == i % MBS + 1, "R7", "macroblock number", int'(mb_num), i % MBS + 1);
            check(int'(gob_num) == 2 * (i / MBS) + 1, "R8", "quarter-res group number",
                  int'(gob_num), 2 * (i / MBS) + 1);
            if (i == 4) begin
                send_mb(100 + i, 10, 1'b0);
                check(err == 1'b0, "R9", "err before short window closes", int'(err), 0);
            end else begin
                send_mb(100 + i, PIX, 1'b0);
            end
            wait_level(1'b0, t_fall);
            if (i == 4)
                check(err == 1'b1, "R9", "err after short window", int'(err), 1);
            t_prev = t_rise;
        end
        check(err == 1'b1, "R9", "err sticky to end of frame", int'(err), 1);
        idle_check();

        // New frame clears error; stray strobe in lead time
        pulse_frame(1'b0, c0);
        check(err == 1'b0, "R9", "err cleared by frame start", int'(err), 0);
        pix     = 8'hA5;
        pix_stb = 1'b1;
        @(negedge clk);
        pix_stb = 1'b0;
        @(negedge clk);
        check(err == 1'b1, "R10", "err after stray strobe", int'(err), 1);
        check(wr_en == 1'b0, "R10", "write from stray strobe", int'(wr_en), 0);
        wait_level(1'b1, t_rise);
        check(int'(mb_num) == 1, "R7", "number restarts on frame start", int'(mb_num), 1);
        check(int'(gob_num) == 1, "R8", "group restarts on frame start", int'(gob_num), 1);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule